// File: doc/BRIEF.md
# Dual-Bank Configuration Register Controller

This block holds a 16-bit configuration word that has no location in the memory map. Software reaches it only through decoded commands: a configuration-read command, a configuration-write command and a reset command. Each command carries a bank address. The block sits in the read-response path of a two-bank memory array. Array responses pass through it as a valid/ready stream. After a configuration-read command, responses for the bank named by that command carry the register contents in place of array data. Responses for the other bank still carry array data.

A configuration write is accepted only while the internal program/erase engine is idle. A write that arrives while the engine reports busy is dropped silently. The register can be read at any time. Four bit positions are reserved: 14, 5, 4 and 3. They never store a 1. Bit 15 selects the read mode, where 1 means asynchronous and 0 means synchronous burst. Bits 13..10 hold the initial access delay and bit 9 holds the output configuration. Bit 8 holds the wait configuration, bit 7 the burst sequence, bit 6 the clock configuration, and bits 2..0 the burst length. The block stores these fields but does not interpret them.

The response stream has no storage. rsp_valid follows arr_valid and arr_ready follows rsp_ready in the same cycle, so back-pressure from the consumer reaches the array directly. Only the data word may be replaced. A response is transferred in any cycle where arr_valid and rsp_ready are both high.

Top module: `cfg_overlay_ctrl`

## Requirements
- R1: After hardware reset the register holds 0x8000, with read mode set to asynchronous, and no bank is overlaid, so both banks return array data.
- R2: A configuration-read command (cmd_valid high, cmd_op = 2'b01) latches cmd_bank on its clock edge. From the next cycle onward, responses whose arr_bank equals the latched bank carry the register on rsp_data[15:0].
- R3: While one bank is overlaid, responses for the other bank carry arr_data unchanged.
- R4: A configuration-read command may name either bank. Issuing it again with a different bank moves the overlay to the new bank and returns the old bank to array data.
- R5: A configuration write (cmd_op = 2'b10) with engine_busy low loads cmd_wdata on its clock edge. Overlaid reads in the following cycle show the new value.
- R6: A configuration write with engine_busy high is dropped, and the register keeps its previous value.
- R7: Bits 14, 5, 4 and 3 of the register always store and read back as 0, whatever value is written.
- R8: An overlaid response drives rsp_data[31:16] to all zeros.
- R9: A reset command (cmd_op = 2'b11) ends the overlay so both banks return array data. The register value is kept.
- R10: The register can be read through the overlay while engine_busy is high.
- R11: rsp_valid equals arr_valid and arr_ready equals rsp_ready in every cycle. The block adds no storage or delay to the response stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 2 | Command: 00 idle, 01 config read, 10 config write, 11 reset |
| cmd_bank | input | 1 | Bank address that comes with the command |
| cmd_wdata | input | 16 | Value for a config write |
| engine_busy | input | 1 | Program/erase engine is running |
| arr_valid | input | 1 | Array response valid |
| arr_ready | output | 1 | Block can accept the array response |
| arr_bank | input | 1 | Bank that the array response belongs to |
| arr_data | input | 32 | Array response data |
| rsp_valid | output | 1 | Response valid toward the consumer |
| rsp_ready | input | 1 | Consumer accepts the response |
| rsp_data | output | 32 | Response data, either array data or the register in place of it |

## Verification
The assertions check on every cycle that the stream handshake passes straight through, that reserved bits stay clear, and that non-overlaid responses equal array data. They also check that overlaid responses have a zero upper half, that a busy write leaves the register unchanged, and that accepted writes and read or reset commands take effect one edge later. Only the bench scenarios can show the full data values a consumer sees over a sequence. These sequences are: reset defaults, a write followed by reads of both banks, moving the overlay between banks, clearing it with a reset command, and restoring the default after a second hardware reset.

// File: rtl/cfg_overlay_pkg.sv
package cfg_overlay_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE   = 2'b00,
    CMD_CFG_RD = 2'b01,
    CMD_CFG_WR = 2'b10,
    CMD_RESET  = 2'b11
  } cmd_op_e;

  // field layout of the configuration word, positions fixed
  typedef struct packed {
    logic       rd_async;    // 15: 1 asynchronous, 0 synchronous burst
    logic       rsv_hi;      // 14: reserved
    logic [3:0] acc_delay;   // 13..10
    logic       out_cfg;     // 9
    logic       wait_cfg;    // 8
    logic       burst_seq;   // 7
    logic       clk_cfg;     // 6
    logic [2:0] rsv_lo;      // 5..3: reserved
    logic [2:0] burst_len;   // 2..0
  } cfg_word_t;

  localparam int unsigned CFG_W = $bits(cfg_word_t);

  localparam logic [CFG_W-1:0] CFG_RESET_VAL = 16'h8000;

  // force reserved fields to zero
  function automatic cfg_word_t cfg_clean(input logic [CFG_W-1:0] raw);
    cfg_word_t w;
    w        = cfg_word_t'(raw);
    w.rsv_hi = 1'b0;
    w.rsv_lo = '0;
    return w;
  endfunction

  // mask of the reserved bit positions, derived from the layout
  function automatic logic [CFG_W-1:0] cfg_rsv_mask();
    cfg_word_t w;
    w        = '0;
    w.rsv_hi = 1'b1;
    w.rsv_lo = '1;
    return logic'(1'b0) ? '0 : w;
  endfunction

endpackage

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_overlay_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_VAL = CFG_RESET_VAL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic             busy,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] cfg_q
);

  localparam logic [CFG_W-1:0] RSV = cfg_rsv_mask();

  cfg_word_t cfg_r;
  logic      wr_ok;

  // writes are gated by the program/erase engine
  assign wr_ok = wr_req && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_r <= cfg_word_t'(RST_VAL & ~RSV);
    end else if (wr_ok) begin
      cfg_r <= cfg_clean(wr_data);
    end
  end

  assign cfg_q = cfg_r;

endmodule

// File: rtl/ovl_track.sv
module ovl_track #(
  parameter int unsigned BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_cmd,
  input  logic              rst_cmd,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic              ovl_on,
  output logic [BANK_W-1:0] ovl_bank
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl_on   <= 1'b0;
      ovl_bank <= '0;
    end else if (rst_cmd) begin
      ovl_on   <= 1'b0;
      ovl_bank <= '0;
    end else if (rd_cmd) begin
      ovl_on   <= 1'b1;
      ovl_bank <= cmd_bank;
    end
  end

endmodule

// File: rtl/rsp_mux.sv
module rsp_mux #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CFG_W  = 16,
  parameter int unsigned BANK_W = 1
) (
  input  logic              ovl_on,
  input  logic [BANK_W-1:0] ovl_bank,
  input  logic [CFG_W-1:0]  cfg_q,
  input  logic [BANK_W-1:0] arr_bank,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] rsp_data
);

  localparam int unsigned NUM_BANKS = 1 << BANK_W;
  localparam int unsigned PAD_W     = DATA_W - CFG_W;

  logic [NUM_BANKS-1:0] bank_hit;
  logic                 sel_cfg;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_hit[b] = ovl_on && (ovl_bank == BANK_W'(b));
  end

  assign sel_cfg  = bank_hit[arr_bank];
  assign rsp_data = sel_cfg ? {{PAD_W{1'b0}}, cfg_q} : arr_data;

endmodule

// File: rtl/cfg_overlay_ctrl.sv
module cfg_overlay_ctrl
  import cfg_overlay_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [CFG_W-1:0]  cmd_wdata,
  input  logic              engine_busy,
  input  logic              arr_valid,
  output logic              arr_ready,
  input  logic [BANK_W-1:0] arr_bank,
  input  logic [DATA_W-1:0] arr_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);

  cmd_op_e           op;
  logic              rd_cmd, wr_cmd, rst_cmd;
  logic [CFG_W-1:0]  cfg_q;
  logic              ovl_on;
  logic [BANK_W-1:0] ovl_bank;

  assign op      = cmd_op_e'(cmd_op);
  assign rd_cmd  = cmd_valid && (op == CMD_CFG_RD);
  assign wr_cmd  = cmd_valid && (op == CMD_CFG_WR);
  assign rst_cmd = cmd_valid && (op == CMD_RESET);

  cfg_store #(.RST_VAL(CFG_RESET_VAL)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_cmd),
    .busy    (engine_busy),
    .wr_data (cmd_wdata),
    .cfg_q   (cfg_q)
  );

  ovl_track #(.BANK_W(BANK_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_cmd   (rd_cmd),
    .rst_cmd  (rst_cmd),
    .cmd_bank (cmd_bank),
    .ovl_on   (ovl_on),
    .ovl_bank (ovl_bank)
  );

  rsp_mux #(.DATA_W(DATA_W), .CFG_W(CFG_W), .BANK_W(BANK_W)) u_mux (
    .ovl_on   (ovl_on),
    .ovl_bank (ovl_bank),
    .cfg_q    (cfg_q),
    .arr_bank (arr_bank),
    .arr_data (arr_data),
    .rsp_data (rsp_data)
  );

  // stream is a pure pass-through for handshake
  assign rsp_valid = arr_valid;
  assign arr_ready = rsp_ready;

endmodule

// File: rtl/cfg_overlay_chk.sv
module cfg_overlay_chk
  import cfg_overlay_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BANK_W = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic [CFG_W-1:0]  cmd_wdata,
  input logic              engine_busy,
  input logic              arr_valid,
  input logic              arr_ready,
  input logic [BANK_W-1:0] arr_bank,
  input logic [DATA_W-1:0] arr_data,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic [CFG_W-1:0]  cfg_q,
  input logic              ovl_on,
  input logic [BANK_W-1:0] ovl_bank
);

  localparam logic [CFG_W-1:0] RSV = cfg_rsv_mask();

  // R11
  handshake_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid == arr_valid) && (arr_ready == rsp_ready));

  // R7
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q & RSV) == '0);

  // R3
  other_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && !(ovl_on && arr_bank == ovl_bank)) |-> rsp_data == arr_data);

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid && ovl_on && arr_bank == ovl_bank) |-> rsp_data[DATA_W-1:CFG_W] == '0);

  // R6
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b10 && engine_busy) |=> $stable(cfg_q));

  // R5
  write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b10 && !engine_busy) |=> cfg_q == ($past(cmd_wdata) & ~RSV));

  // R2
  bank_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b01) |=> (ovl_on && ovl_bank == $past(cmd_bank)));

  // R9
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b11) |=> (!ovl_on && $stable(cfg_q)));

endmodule

bind cfg_overlay_ctrl cfg_overlay_chk #(.DATA_W(DATA_W), .BANK_W(BANK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_op      (cmd_op),
  .cmd_bank    (cmd_bank),
  .cmd_wdata   (cmd_wdata),
  .engine_busy (engine_busy),
  .arr_valid   (arr_valid),
  .arr_ready   (arr_ready),
  .arr_bank    (arr_bank),
  .arr_data    (arr_data),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_data    (rsp_data),
  .cfg_q       (cfg_q),
  .ovl_on      (ovl_on),
  .ovl_bank    (ovl_bank)
);

// File: tb/sim_cfg_overlay_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_overlay_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [0:0]  cmd_bank;
  logic [15:0] cmd_wdata;
  logic        engine_busy;
  logic        arr_valid;
  logic        arr_ready;
  logic [0:0]  arr_bank;
  logic [31:0] arr_data;
  logic        rsp_valid;
  logic        rsp_ready;
  logic [31:0] rsp_data;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  cfg_overlay_ctrl u0 (
    .clk (clk), .rst_n (rst_n),
    .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_bank (cmd_bank),
    .cmd_wdata (cmd_wdata), .engine_busy (engine_busy),
    .arr_valid (arr_valid), .arr_ready (arr_ready), .arr_bank (arr_bank),
    .arr_data (arr_data), .rsp_valid (rsp_valid), .rsp_ready (rsp_ready),
    .rsp_data (rsp_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  // one command, captured on the next rising edge
  task automatic send_cmd(input logic [1:0] op, input logic bank, input logic [15:0] wd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_bank = bank; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
  endtask

  // present an array response and check the output word
  task automatic read_chk(input string tag, input logic bank, input logic [31:0] ad,
                          input logic [31:0] exp);
    arr_valid = 1'b1; arr_bank = bank; arr_data = ad; rsp_ready = 1'b1;
    #1;
    chk(tag, rsp_data, exp);
    arr_valid = 1'b0;
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_state();
    read_chk("R1 bank0 array after reset", 1'b0, 32'hA5A5_0001, 32'hA5A5_0001);
    read_chk("R1 bank1 array after reset", 1'b1, 32'h5A5A_0002, 32'h5A5A_0002);
    send_cmd(2'b01, 1'b0, 16'h0000);
    read_chk("R1 R2 R8 default register on bank0", 1'b0, 32'hFFFF_FFFF, 32'h0000_8000);
  endtask

  task automatic t_write();
    send_cmd(2'b10, 1'b1, 16'hFFFF);
    read_chk("R5 R7 write all ones, reserved clear", 1'b0, 32'h1234_5678, 32'h0000_BFC7);
    read_chk("R3 other bank keeps array data", 1'b1, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
    send_cmd(2'b10, 1'b0, 16'h2A5D);
    read_chk("R5 R7 second pattern", 1'b0, 32'hFFFF_0000, 32'h0000_2A45);
  endtask

  task automatic t_busy();
    engine_busy = 1'b1;
    send_cmd(2'b10, 1'b0, 16'h1234);
    read_chk("R6 R10 busy write dropped, read while busy", 1'b0, 32'h0BAD_0BAD, 32'h0000_2A45);
    engine_busy = 1'b0;
    send_cmd(2'b10, 1'b0, 16'h0001);
    read_chk("R5 write after busy ends", 1'b0, 32'h0, 32'h0000_0001);
  endtask

  task automatic t_rebank();
    send_cmd(2'b01, 1'b1, 16'h0000);
    read_chk("R4 overlay moved to bank1", 1'b1, 32'hCAFE_F00D, 32'h0000_0001);
    read_chk("R4 bank0 back to array", 1'b0, 32'hCAFE_F00D, 32'hCAFE_F00D);
  endtask

  task automatic t_reset_cmd();
    send_cmd(2'b11, 1'b0, 16'h0000);
    read_chk("R9 bank0 array after reset cmd", 1'b0, 32'h1111_2222, 32'h1111_2222);
    read_chk("R9 bank1 array after reset cmd", 1'b1, 32'h3333_4444, 32'h3333_4444);
    send_cmd(2'b01, 1'b1, 16'h0000);
    read_chk("R9 register value kept", 1'b1, 32'h0, 32'h0000_0001);
  endtask

  task automatic t_stream();
    arr_valid = 1'b1; rsp_ready = 1'b0; arr_bank = 1'b0; arr_data = 32'h77;
    #1;
    chk("R11 valid passes", {31'd0, rsp_valid}, 32'd1);
    chk("R11 ready back-pressure", {31'd0, arr_ready}, 32'd0);
    arr_valid = 1'b0; rsp_ready = 1'b1;
    #1;
    chk("R11 idle valid", {31'd0, rsp_valid}, 32'd0);
    chk("R11 ready passes", {31'd0, arr_ready}, 32'd1);
  endtask

  task automatic t_hw_reset();
    hw_reset();
    read_chk("R1 overlay cleared by hardware reset", 1'b1, 32'h9999_0000, 32'h9999_0000);
    send_cmd(2'b01, 1'b1, 16'h0000);
    read_chk("R1 register restored to default", 1'b1, 32'h0, 32'h0000_8000);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_bank = 1'b0;
    cmd_wdata = 16'h0; engine_busy = 1'b0; arr_valid = 1'b0; arr_bank = 1'b0;
    arr_data = 32'h0; rsp_ready = 1'b1;
    hw_reset();
    t_reset_state();
    t_write();
    t_busy();
    t_rebank();
    t_reset_cmd();
    t_stream();
    t_hw_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule